// File: doc/BRIEF.md
# Registered Integer Execution Unit

This unit evaluates one integer operation per clock for a simple load/store processor pipeline. Each cycle it takes two 32-bit source operands, a 16-bit instruction constant, a 5-bit shift count and a 5-bit operation code. On the next rising clock edge it presents the 32-bit result and a flag that is high when that result is zero. The flag is what an equality branch tests after a subtraction.

The operation set covers wrapping add and subtract, bitwise AND, OR and NOR, and signed and unsigned less-than compares. It also covers left, logical-right and arithmetic-right shifts and the upper-constant load. A register form and a constant form exist for add, AND, OR and both compares. The unit widens the constant in whichever way the operation code calls for: it copies the sign bit, fills with zeros, or moves the constant into the upper half. Operation codes outside the defined set give a result of zero.

Top module: `exu_core`

## Requirements
- R1: Code 0 gives src_a + src_b and code 1 gives src_a - src_b, both modulo 2^32 with no overflow indication. The result appears on result_q after the rising edge that samples the inputs.
- R2: Code 2 gives src_a & src_b, code 3 gives src_a | src_b and code 4 gives ~(src_a | src_b).
- R3: Code 5 gives 1 if src_a < src_b as two's-complement values and 0 otherwise. Code 6 gives the same comparison taken as unsigned values.
- R4: Code 7 shifts src_a left by shift_amt, and code 8 shifts it right by shift_amt, both filling with zeros. Code 9 shifts it right and fills with copies of src_a[31]. The shift count comes only from shift_amt, and src_b has no effect.
- R5: Code 15 places imm in bits 31:16 of the result and zeros in bits 15:0.
- R6: Code 10 gives src_a plus imm sign-extended from bit 15. Code 13 gives 1 if src_a is less than that sign-extended value as signed numbers, and 0 otherwise.
- R7: Code 11 gives src_a AND imm zero-extended to 32 bits, and code 12 gives src_a OR imm zero-extended to 32 bits.
- R8: Code 14 sign-extends imm from bit 15 and gives 1 if src_a is less than the extended value compared as unsigned numbers, and 0 otherwise.
- R9: zero_q is high exactly when result_q is all zeros.
- R10: Codes 16 to 31 give a result of zero.
- R11: While rst_n is low, result_q is 0 and zero_q is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 5 | Operation code |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| imm | input | 16 | Instruction constant |
| shift_amt | input | 5 | Shift count |
| result_q | output | 32 | Registered result |
| zero_q | output | 1 | Registered result-is-zero flag |

## Verification
Every result also drives the zero flag. Both outputs are registered in the same edge, so an arithmetic wrap, a failed compare or a shift that pushes out every set bit must raise zero_q in the same cycle that result_q becomes zero. Directed cases aim at these collisions: all-ones plus one, subtracting equal values, shifting a single top bit off the word, and an unknown code. Random operands are also driven under every code, with src_b and imm varied even where they should not matter. Each cycle both outputs are compared against a bench model of the operation, and the flag is checked against the expected result.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int XLEN    = 32;
    localparam int IMMW    = 16;
    localparam int SHW     = $clog2(XLEN);
    localparam int OPW     = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_AND   = 5'd2,
        OP_OR    = 5'd3,
        OP_NOR   = 5'd4,
        OP_SLT   = 5'd5,
        OP_SLTU  = 5'd6,
        OP_SLL   = 5'd7,
        OP_SRL   = 5'd8,
        OP_SRA   = 5'd9,
        OP_ADDI  = 5'd10,
        OP_ANDI  = 5'd11,
        OP_ORI   = 5'd12,
        OP_SLTI  = 5'd13,
        OP_SLTIU = 5'd14,
        OP_LUI   = 5'd15
    } op_e;

    typedef enum logic [1:0] {
        EXT_SIGN,
        EXT_ZERO,
        EXT_UPPER
    } ext_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_OR,
        LG_NOR
    } logic_e;

    typedef enum logic [2:0] {
        SEL_ZERO,
        SEL_SUM,
        SEL_LOGIC,
        SEL_LT_S,
        SEL_LT_U,
        SEL_SHIFT,
        SEL_IMM
    } res_sel_e;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            zero;
    } exu_state_t;

endpackage

// File: rtl/exu_imm_ext.sv
module exu_imm_ext
    import exu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IW    = 16
) (
    input  logic [IW-1:0]    imm,
    input  ext_e             mode,
    output logic [WIDTH-1:0] ext
);
    localparam int PAD = WIDTH - IW;

    always_comb begin
        unique case (mode)
            EXT_SIGN:  ext = {{PAD{imm[IW-1]}}, imm};
            EXT_ZERO:  ext = {{PAD{1'b0}}, imm};
            EXT_UPPER: ext = {imm, {PAD{1'b0}}};
            default:   ext = '0;
        endcase
    end

    always_comb begin
        if (mode == EXT_ZERO)
            AST_ZEXT_TOP_CLEAR: assert (ext[WIDTH-1:IW] == '0); // R7
    end

endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             lt_s,
    output logic             lt_u
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] opb_x;
    logic [WIDTH:0]   wide;
    logic             carry;
    logic             ovf;

    always_comb begin
        opb_x = sub ? ~opb : opb;
        wide  = {1'b0, opa} + {1'b0, opb_x} + {{WIDTH{1'b0}}, sub};
        sum   = wide[MSB:0];
        carry = wide[WIDTH];
        ovf   = (opa[MSB] == opb_x[MSB]) && (sum[MSB] != opa[MSB]);
        lt_s  = sum[MSB] ^ ovf;
        lt_u  = ~carry;
    end

endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
    parameter int WIDTH = 32,
    parameter int AW    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AW-1:0]    amt,
    input  logic             left,
    input  logic             arith,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] rev_in;
    logic [WIDTH-1:0] rev_out;
    logic [WIDTH-1:0] stage [0:AW];
    logic             fill;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_rev
            assign rev_in[i]  = din[WIDTH-1-i];
            assign rev_out[i] = stage[AW][WIDTH-1-i];
        end
    endgenerate

    assign fill     = arith & ~left & din[WIDTH-1];
    assign stage[0] = left ? rev_in : din;

    generate
        for (genvar k = 0; k < AW; k++) begin : g_stage
            localparam int STEP = 1 << k;
            assign stage[k+1] = amt[k]
                ? {{STEP{fill}}, stage[k][WIDTH-1:STEP]}
                : stage[k];
        end
    endgenerate

    assign dout = left ? rev_out : stage[AW];

    always_comb begin
        if (!left && !arith && amt != '0)
            AST_SRL_TOP_ZERO: assert (dout[WIDTH-1] == 1'b0); // R4
    end

endmodule

// File: rtl/exu_logic.sv
module exu_logic
    import exu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic_e           sel,
    output logic [WIDTH-1:0] dout
);
    always_comb begin
        unique case (sel)
            LG_AND:  dout = opa & opb;
            LG_OR:   dout = opa | opb;
            LG_NOR:  dout = ~(opa | opb);
            default: dout = '0;
        endcase
    end

endmodule

// File: rtl/exu_core.sv
module exu_core
    import exu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      op_sel,
    input  logic [31:0]     src_a,
    input  logic [31:0]     src_b,
    input  logic [15:0]     imm,
    input  logic [4:0]      shift_amt,
    output logic [31:0]     result_q,
    output logic            zero_q
);
    typedef struct packed {
        ext_e     ext_mode;
        logic     use_imm;
        logic     sub;
        logic_e   lg_sel;
        logic     sh_left;
        logic     sh_arith;
        res_sel_e res_sel;
    } dec_t;

    dec_t             dec;
    logic [XLEN-1:0]  imm_x;
    logic [XLEN-1:0]  opnd_b;
    logic [XLEN-1:0]  sum;
    logic             lt_s;
    logic             lt_u;
    logic [XLEN-1:0]  sh_out;
    logic [XLEN-1:0]  lg_out;
    exu_state_t       state_d;
    exu_state_t       state_q;

    // operation decode
    always_comb begin
        dec          = '0;
        dec.ext_mode = EXT_SIGN;
        dec.lg_sel   = LG_AND;
        dec.res_sel  = SEL_ZERO;
        unique case (op_sel)
            OP_ADD:   dec.res_sel = SEL_SUM;
            OP_SUB:   begin dec.sub = 1'b1; dec.res_sel = SEL_SUM; end
            OP_AND:   begin dec.lg_sel = LG_AND; dec.res_sel = SEL_LOGIC; end
            OP_OR:    begin dec.lg_sel = LG_OR;  dec.res_sel = SEL_LOGIC; end
            OP_NOR:   begin dec.lg_sel = LG_NOR; dec.res_sel = SEL_LOGIC; end
            OP_SLT:   begin dec.sub = 1'b1; dec.res_sel = SEL_LT_S; end
            OP_SLTU:  begin dec.sub = 1'b1; dec.res_sel = SEL_LT_U; end
            OP_SLL:   begin dec.sh_left = 1'b1; dec.res_sel = SEL_SHIFT; end
            OP_SRL:   dec.res_sel = SEL_SHIFT;
            OP_SRA:   begin dec.sh_arith = 1'b1; dec.res_sel = SEL_SHIFT; end
            OP_ADDI:  begin dec.use_imm = 1'b1; dec.res_sel = SEL_SUM; end
            OP_ANDI:  begin
                dec.use_imm  = 1'b1;
                dec.ext_mode = EXT_ZERO;
                dec.lg_sel   = LG_AND;
                dec.res_sel  = SEL_LOGIC;
            end
            OP_ORI:   begin
                dec.use_imm  = 1'b1;
                dec.ext_mode = EXT_ZERO;
                dec.lg_sel   = LG_OR;
                dec.res_sel  = SEL_LOGIC;
            end
            OP_SLTI:  begin
                dec.use_imm = 1'b1;
                dec.sub     = 1'b1;
                dec.res_sel = SEL_LT_S;
            end
            OP_SLTIU: begin
                dec.use_imm = 1'b1;
                dec.sub     = 1'b1;
                dec.res_sel = SEL_LT_U;
            end
            OP_LUI:   begin
                dec.ext_mode = EXT_UPPER;
                dec.res_sel  = SEL_IMM;
            end
            default:  dec.res_sel = SEL_ZERO;
        endcase
    end

    exu_imm_ext #(.WIDTH(XLEN), .IW(IMMW)) u_imm_ext (
        .imm  (imm),
        .mode (dec.ext_mode),
        .ext  (imm_x)
    );

    assign opnd_b = dec.use_imm ? imm_x : src_b;

    exu_addsub #(.WIDTH(XLEN)) u_addsub (
        .opa  (src_a),
        .opb  (opnd_b),
        .sub  (dec.sub),
        .sum  (sum),
        .lt_s (lt_s),
        .lt_u (lt_u)
    );

    exu_shifter #(.WIDTH(XLEN), .AW(SHW)) u_shifter (
        .din   (src_a),
        .amt   (shift_amt),
        .left  (dec.sh_left),
        .arith (dec.sh_arith),
        .dout  (sh_out)
    );

    exu_logic #(.WIDTH(XLEN)) u_logic (
        .opa  (src_a),
        .opb  (opnd_b),
        .sel  (dec.lg_sel),
        .dout (lg_out)
    );

    // next-state computation
    always_comb begin
        state_d = state_q;
        unique case (dec.res_sel)
            SEL_SUM:   state_d.result = sum;
            SEL_LOGIC: state_d.result = lg_out;
            SEL_LT_S:  state_d.result = {{(XLEN-1){1'b0}}, lt_s};
            SEL_LT_U:  state_d.result = {{(XLEN-1){1'b0}}, lt_u};
            SEL_SHIFT: state_d.result = sh_out;
            SEL_IMM:   state_d.result = imm_x;
            default:   state_d.result = '0;
        endcase
        state_d.zero = (state_d.result == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.result <= '0;
            state_q.zero   <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_q = state_q.result;
    assign zero_q   = state_q.zero;

    AST_ZERO_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        zero_q == (result_q == '0)); // R9

    AST_LUI_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_LUI) |=> (result_q[IMMW-1:0] == '0)); // R5

    AST_CMP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SLT || op_sel == OP_SLTU || op_sel == OP_SLTI
         || op_sel == OP_SLTIU) |=> (result_q[XLEN-1:1] == '0)); // R3

    AST_UNKNOWN_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > OP_LUI) |=> (result_q == '0 && zero_q)); // R10

    AST_SRA_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SRA && src_a[XLEN-1]) |=> result_q[XLEN-1]); // R4

    AST_ORI_TOP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_ORI) |=> (result_q[XLEN-1:IMMW] == $past(src_a[XLEN-1:IMMW]))); // R7

    AST_SUB_SELF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SUB && src_a == src_b) |=> zero_q); // R1

endmodule

// File: tb/exu_core_bench.sv
module exu_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm = '0;
    logic [4:0]  shift_amt = '0;
    logic [31:0] result_q;
    logic        zero_q;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10ns clk = ~clk;

    exu_core u_exu_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_sel    (op_sel),
        .src_a     (src_a),
        .src_b     (src_b),
        .imm       (imm),
        .shift_amt (shift_amt),
        .result_q  (result_q),
        .zero_q    (zero_q)
    );

    function automatic logic [31:0] model(input logic [4:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [15:0] k,
                                          input logic [4:0] sh);
        logic [31:0] sx = {{16{k[15]}}, k};
        logic [31:0] zx = {16'h0000, k};
        case (op)
            5'd0:  return a + b;
            5'd1:  return a - b;
            5'd2:  return a & b;
            5'd3:  return a | b;
            5'd4:  return ~(a | b);
            5'd5:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            5'd6:  return (a < b) ? 32'd1 : 32'd0;
            5'd7:  return a << sh;
            5'd8:  return a >> sh;
            5'd9:  return $unsigned($signed(a) >>> sh);
            5'd10: return a + sx;
            5'd11: return a & zx;
            5'd12: return a | zx;
            5'd13: return ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
            5'd14: return (a < sx) ? 32'd1 : 32'd0;
            5'd15: return {k, 16'h0000};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1:          return "R1";
            5'd2, 5'd3, 5'd4:    return "R2";
            5'd5, 5'd6:          return "R3";
            5'd7, 5'd8, 5'd9:    return "R4";
            5'd15:               return "R5";
            5'd10, 5'd13:        return "R6";
            5'd11, 5'd12:        return "R7";
            5'd14:               return "R8";
            default:             return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] k, input logic [4:0] sh);
        logic [31:0] exp;
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b; imm = k; shift_amt = sh;
        exp = model(op, a, b, k, sh);
        @(negedge clk);
        check(req_of(op), result_q, exp);
        check("R9", {31'd0, zero_q}, {31'd0, exp == 32'd0});
    endtask

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        // R11: reset state, with busy inputs
        op_sel = 5'd0; src_a = 32'h1234_5678; src_b = 32'h1;
        repeat (3) @(negedge clk);
        check("R11", result_q, 32'd0);
        check("R11", {31'd0, zero_q}, 32'd1);
        rst_n = 1'b1;

        // R1: wrap and equal subtract
        run_op(5'd0, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        run_op(5'd1, 32'h0000_0000, 32'h1, 16'h0, 5'd0);
        run_op(5'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0, 5'd0);
        // R2
        run_op(5'd4, 32'h0000_0000, 32'h0000_0000, 16'h0, 5'd0);
        run_op(5'd2, 32'h0000_0008, 32'h0000_000C, 16'h0, 5'd0);
        // R3: signed and unsigned disagree
        run_op(5'd5, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        run_op(5'd6, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        run_op(5'd5, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0);
        // R4: fill behaviour, src_b does not steer the count
        run_op(5'd9, 32'h8000_0000, 32'h3, 16'h0, 5'd31);
        run_op(5'd8, 32'h8000_0000, 32'h3, 16'h0, 5'd31);
        run_op(5'd7, 32'h8000_0001, 32'h5, 16'h0, 5'd1);
        run_op(5'd7, 32'hA5A5_A5A5, 32'h1F, 16'h0, 5'd0);
        // R5 then R7 build a constant
        run_op(5'd15, 32'hFFFF_FFFF, 32'h0, 16'hABCD, 5'd0);
        run_op(5'd12, 32'hABCD_0000, 32'h0, 16'h1234, 5'd0);
        run_op(5'd11, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0);
        // R6
        run_op(5'd10, 32'h0000_8000, 32'h0, 16'h8000, 5'd0);
        run_op(5'd13, 32'h0000_0005, 32'h0, 16'hFFFF, 5'd0);
        // R8: sign-extended constant compared unsigned
        run_op(5'd14, 32'h0000_0005, 32'h0, 16'hFFFF, 5'd0);
        run_op(5'd14, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0);
        // R10
        run_op(5'd16, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd7);
        run_op(5'd31, 32'h1, 32'h1, 16'h1, 5'd1);

        // random mix over every code
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            ra = $urandom();
            rb = ((i % 5) == 0) ? ra : $urandom();
            run_op(5'($urandom()), ra, rb, 16'($urandom()), 5'($urandom()));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule